// File: doc/BRIEF.md
# Multi-Size Translation Buffer with Domain Access Checks

This block is a fully associative address translation buffer that serves one memory port. Instruction fetch and data access each get their own instance. A request carries a 32-bit virtual address, a write flag and a privilege flag. On a hit the block returns the physical address one cycle later. With the address it returns two separate fault flags, one for domain violations and one for permission violations. Each entry maps a page of one of four sizes, so every entry compares a different number of upper address bits and passes a different number of offset bits straight through.

On a miss the block raises `busy` and presents a walk request with the missing address. It then waits for an external table walker to answer with a frame address, a page size, a domain number and a 2-bit permission code. The answer is written into the entry named by a round-robin pointer, and the held request is replayed internally. The response then follows one cycle after the fill.

Access rights are checked against a 32-bit domain control word that holds two bits for each of 16 domains. The entry's domain selects which two bits apply. Those two bits choose one of three behaviours: check the entry's permission code, skip the check, or fault on every access.

Top module: `xlat_tlb`

## Requirements
- R1: Reset sets busy, rsp_valid and walk_req to 0 and empties the buffer. A request accepted while idle that hits gives a one-cycle rsp_valid pulse on the next clock. The physical address equals the entry's frame bits above the page offset, joined with the request's own offset bits.
- R2: fill_size codes the page size as 00 = 1 MB (offset bits 19:0), 01 = 64 KB (15:0), 10 = 16 KB (13:0) and 11 = 1 KB (9:0). An entry matches any address whose bits above its offset equal the stored tag.
- R3: A request that misses sets busy and walk_req from the next clock. walk_vaddr holds the request address and no response is given until walk_ack is seen.
- R4: The clock edge on which walk_ack is high writes the fill. The replayed lookup responds on the following edge. Later requests to the same page hit with no walk.
- R5: Domain d uses bits [2d+1:2d] of dom_access. Code 00 and the reserved code 10 raise rsp_dom_fault on every access. Code 11 accepts every access without looking at the permission code.
- R6: Code 01 applies the permission code. Code 00 allows only privileged reads. Code 01 allows privileged reads and writes. Code 10 also allows user reads. Code 11 allows everything. A refused access raises rsp_perm_fault.
- R7: Domain and permission faults never occur together. The physical address is returned whether or not a fault is raised.
- R8: inval_all clears every valid bit in one cycle and sets the replacement pointer back to entry 0. A fill written in the same cycle survives.
- R9: Fills go to entries in round-robin order. With all entries full, the next fill evicts the oldest one.
- R10: When several valid entries match, the lowest-numbered one supplies the result. A fill never duplicates a mapping that already hits.
- R11: New requests and walk_ack outside a pending walk are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_priv | input | 1 | 1 = privileged access |
| dom_access | input | 32 | Two mode bits for each of 16 domains |
| inval_all | input | 1 | Clear all entries |
| busy | output | 1 | Miss being resolved |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_dom_fault | output | 1 | Domain fault |
| rsp_perm_fault | output | 1 | Permission fault |
| walk_req | output | 1 | Table walk wanted |
| walk_vaddr | output | 32 | Address to walk |
| walk_ack | input | 1 | Fill data valid |
| fill_pframe | input | 32 | Physical frame base from walker |
| fill_size | input | 2 | Page size code of the fill |
| fill_dom | input | 4 | Domain number of the fill |
| fill_ap | input | 2 | Permission code of the fill |

## Verification
The bench aims at the page-size boundaries. It sends addresses just inside and just past each size's frame. A design that masked the wrong number of tag bits would hit where it should walk, or splice in the wrong offset bits. It overlaps a 1 KB entry with a later 64 KB entry covering the same address, so a priority encoder that favoured the higher index would return the large-page frame. It fills all 64 entries and then one more to expose a replacement pointer that skips or repeats. It pokes requests during a walk and pulses invalidate before reusing a page, which catches a sequencer that accepts work while busy or an invalidate that leaves stale hits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W     = 32;
    localparam int MIN_OFF  = 10;
    localparam int TAG_W    = VA_W - MIN_OFF;
    localparam int NUM_DOM  = 16;
    localparam int DOM_W    = $clog2(NUM_DOM);
    localparam int DACR_W   = 2 * NUM_DOM;

    typedef enum logic [1:0] {
        PG_SECTION = 2'b00,
        PG_LARGE   = 2'b01,
        PG_SMALL   = 2'b10,
        PG_TINY    = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        DM_NONE    = 2'b00,
        DM_CLIENT  = 2'b01,
        DM_RSVD    = 2'b10,
        DM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WALK   = 2'b01,
        ST_REPLAY = 2'b10
    } ctl_state_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  vtag;
        logic [TAG_W-1:0]  ptag;
        pg_size_e          size;
        logic [DOM_W-1:0]  dom;
        logic [1:0]        ap;
    } tlb_entry_t;

    // Tag bits (address bits above MIN_OFF) that take part in the compare.
    function automatic logic [TAG_W-1:0] tag_keep(input pg_size_e sz);
        logic [TAG_W-1:0] k;
        case (sz)
            PG_SECTION: k = {{(VA_W-20){1'b1}}, {(20-MIN_OFF){1'b0}}};
            PG_LARGE:   k = {{(VA_W-16){1'b1}}, {(16-MIN_OFF){1'b0}}};
            PG_SMALL:   k = {{(VA_W-14){1'b1}}, {(14-MIN_OFF){1'b0}}};
            default:    k = {TAG_W{1'b1}};
        endcase
        return k;
    endfunction

    // Client-mode permission decode.
    function automatic logic ap_allows(input logic [1:0] ap,
                                       input logic priv, input logic wr);
        logic ok;
        case (ap)
            2'b00:   ok = priv && !wr;
            2'b01:   ok = priv;
            2'b10:   ok = priv || !wr;
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_all,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    output logic              hit,
    output tlb_entry_t        hit_entry
);

    tlb_entry_t          ent_q [ENTRIES];
    logic [ENTRIES-1:0]  vld;
    logic [ENTRIES-1:0]  match;
    logic [IDX_W-1:0]    sel_idx;
    logic                found;
    logic [TAG_W-1:0]    lk_tag;

    assign lk_tag = lk_vaddr[VA_W-1:MIN_OFF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
        end else begin
            if (inval_all) begin
                for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
            end
            if (wr_en) ent_q[wr_idx] <= wr_entry;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign vld[g]   = ent_q[g].valid;
            assign match[g] = vld[g] &&
                (((ent_q[g].vtag ^ lk_tag) & tag_keep(ent_q[g].size)) == '0);
        end
    endgenerate

    // Lowest index wins.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i] && !found) begin
                found   = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    assign hit       = found;
    assign hit_entry = ent_q[sel_idx];

    AST_INVAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> ($countones(vld) <= 1)); // R8

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((match & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0)); // R10

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  logic [DACR_W-1:0] dom_access,
    input  logic [DOM_W-1:0]  dom,
    input  logic [1:0]        ap,
    input  logic              priv,
    input  logic              wr,
    output logic              dom_fault,
    output logic              perm_fault
);

    dom_mode_e mode;

    assign mode = dom_mode_e'(dom_access[2*dom +: 2]);

    always_comb begin
        dom_fault  = 1'b0;
        perm_fault = 1'b0;
        case (mode)
            DM_MANAGER: ;
            DM_CLIENT:  perm_fault = !ap_allows(ap, priv, wr);
            default:    dom_fault  = 1'b1;
        endcase
    end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              hit,
    input  logic              walk_ack,
    input  logic              inval_all,
    output ctl_state_e        state,
    output logic              accept,
    output logic              rsp_fire,
    output logic              fill_we,
    output logic [IDX_W-1:0]  rr_idx
);

    ctl_state_e state_d;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign fill_we  = (state == ST_WALK) && walk_ack;
    assign rsp_fire = (accept && hit) || ((state == ST_REPLAY) && hit);

    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE:   if (accept && !hit) state_d = ST_WALK;
            ST_WALK:   if (walk_ack) state_d = ST_REPLAY;
            ST_REPLAY: state_d = hit ? ST_IDLE : ST_WALK;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst || inval_all) begin
            rr_idx <= '0;
        end else if (fill_we) begin
            rr_idx <= (rr_idx == IDX_W'(ENTRIES - 1)) ? '0 : rr_idx + 1'b1;
        end
    end

    AST_RR_MOVES: assert property (@(posedge clk) disable iff (rst)
        (fill_we && !inval_all) |=> (rr_idx != $past(rr_idx))); // R9

    AST_REPLAY_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        fill_we |=> (state == ST_REPLAY)); // R4

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [31:0]  req_vaddr,
    input  logic         req_write,
    input  logic         req_priv,
    input  logic [31:0]  dom_access,
    input  logic         inval_all,
    output logic         busy,
    output logic         rsp_valid,
    output logic [31:0]  rsp_paddr,
    output logic         rsp_dom_fault,
    output logic         rsp_perm_fault,
    output logic         walk_req,
    output logic [31:0]  walk_vaddr,
    input  logic         walk_ack,
    input  logic [31:0]  fill_pframe,
    input  logic [1:0]   fill_size,
    input  logic [3:0]   fill_dom,
    input  logic [1:0]   fill_ap
);

    localparam int IDX_W = $clog2(ENTRIES);

    ctl_state_e          state;
    logic                accept, rsp_fire, fill_we;
    logic [IDX_W-1:0]    rr_idx;
    logic                cam_hit;
    tlb_entry_t          hit_entry, fill_entry;
    logic [VA_W-1:0]     hold_vaddr, lk_vaddr;
    logic                hold_wr, hold_priv, lk_wr, lk_priv;
    logic                dom_fault, perm_fault;
    logic [TAG_W-1:0]    keep_hit, keep_fill, out_tag;

    // Request capture: lookups use the live request when idle, the held one otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vaddr <= '0;
            hold_wr    <= 1'b0;
            hold_priv  <= 1'b0;
        end else if (accept) begin
            hold_vaddr <= req_vaddr;
            hold_wr    <= req_write;
            hold_priv  <= req_priv;
        end
    end

    assign lk_vaddr = (state == ST_IDLE) ? req_vaddr : hold_vaddr;
    assign lk_wr    = (state == ST_IDLE) ? req_write : hold_wr;
    assign lk_priv  = (state == ST_IDLE) ? req_priv  : hold_priv;

    // Fill entry built from the walker's answer, tags aligned to the page size.
    assign keep_fill        = tag_keep(pg_size_e'(fill_size));
    assign fill_entry.valid = 1'b1;
    assign fill_entry.vtag  = hold_vaddr[VA_W-1:MIN_OFF] & keep_fill;
    assign fill_entry.ptag  = fill_pframe[VA_W-1:MIN_OFF] & keep_fill;
    assign fill_entry.size  = pg_size_e'(fill_size);
    assign fill_entry.dom   = fill_dom;
    assign fill_entry.ap    = fill_ap;

    xlat_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hit       (cam_hit),
        .walk_ack  (walk_ack),
        .inval_all (inval_all),
        .state     (state),
        .accept    (accept),
        .rsp_fire  (rsp_fire),
        .fill_we   (fill_we),
        .rr_idx    (rr_idx)
    );

    xlat_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .inval_all (inval_all),
        .lk_vaddr  (lk_vaddr),
        .wr_en     (fill_we),
        .wr_idx    (rr_idx),
        .wr_entry  (fill_entry),
        .hit       (cam_hit),
        .hit_entry (hit_entry)
    );

    xlat_perm u_perm (
        .dom_access (dom_access),
        .dom        (hit_entry.dom),
        .ap         (hit_entry.ap),
        .priv       (lk_priv),
        .wr         (lk_wr),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault)
    );

    // Physical address: frame bits above the page offset, request bits below it.
    assign keep_hit = tag_keep(hit_entry.size);
    assign out_tag  = (hit_entry.ptag & keep_hit) |
                      (lk_vaddr[VA_W-1:MIN_OFF] & ~keep_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_dom_fault  <= 1'b0;
            rsp_perm_fault <= 1'b0;
        end else begin
            rsp_valid <= rsp_fire;
            if (rsp_fire) begin
                rsp_paddr      <= {out_tag, lk_vaddr[MIN_OFF-1:0]};
                rsp_dom_fault  <= dom_fault;
                rsp_perm_fault <= perm_fault;
            end
        end
    end

    assign busy       = (state != ST_IDLE);
    assign walk_req   = (state == ST_WALK);
    assign walk_vaddr = hold_vaddr;

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vaddr))); // R3

    AST_WALK_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !rsp_valid); // R3

    AST_FILL_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> !cam_hit); // R10

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_dom_fault && rsp_perm_fault)); // R7

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(walk_vaddr)); // R11

endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_priv;
    logic [31:0] req_vaddr, dom_access;
    logic        inval_all;
    logic        busy, rsp_valid, rsp_dom_fault, rsp_perm_fault, walk_req;
    logic [31:0] rsp_paddr, walk_vaddr;
    logic        walk_ack;
    logic [31:0] fill_pframe;
    logic [1:0]  fill_size, fill_ap;
    logic [3:0]  fill_dom;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] ovr_frame = 32'h7770_0000;
    logic [1:0]  ovr_size  = 2'b01;
    logic [3:0]  ovr_dom   = 4'd5;
    logic [1:0]  ovr_ap    = 2'b11;

    always #2 clk = ~clk;

    xlat_tlb u_xlat_tlb (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_priv(req_priv), .dom_access(dom_access),
        .inval_all(inval_all), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_dom_fault(rsp_dom_fault),
        .rsp_perm_fault(rsp_perm_fault), .walk_req(walk_req),
        .walk_vaddr(walk_vaddr), .walk_ack(walk_ack), .fill_pframe(fill_pframe),
        .fill_size(fill_size), .fill_dom(fill_dom), .fill_ap(fill_ap)
    );

    // Reference page table: bits 29:28 pick the size code.
    function automatic int off_bits(input logic [1:0] sz);
        case (sz)
            2'b00:   return 20;
            2'b01:   return 16;
            2'b10:   return 14;
            default: return 10;
        endcase
    endfunction

    function automatic logic [1:0] pt_size(input logic [31:0] va);
        return va[29:28];
    endfunction

    function automatic logic [31:0] pt_frame(input logic [31:0] va);
        int o = off_bits(va[29:28]);
        return ((va ^ 32'h9000_0000) >> o) << o;
    endfunction

    function automatic logic [3:0] pt_dom(input logic [31:0] va);
        logic [31:0] s = va >> off_bits(va[29:28]);
        return s[3:0];
    endfunction

    function automatic logic [1:0] pt_ap(input logic [31:0] va);
        logic [31:0] s = va >> (off_bits(va[29:28]) + 4);
        return s[1:0];
    endfunction

    // Returns {domain fault, permission fault}.
    function automatic logic [1:0] ref_fault(input logic [3:0] dom, input logic [1:0] ap,
                                             input logic wr, input logic priv,
                                             input logic [31:0] dacr);
        logic [1:0] m = dacr[2*dom +: 2];
        logic ok;
        case (ap)
            2'b00:   ok = priv && !wr;
            2'b01:   ok = priv;
            2'b10:   ok = priv || !wr;
            default: ok = 1'b1;
        endcase
        case (m)
            2'b11:   return 2'b00;
            2'b01:   return {1'b0, !ok};
            default: return 2'b10;
        endcase
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic wr, input logic priv,
                          input logic [31:0] dacr, input logic exp_miss,
                          input int wdelay, input logic poke, input logic use_ovr);
        logic [31:0] frame, exp_pa;
        logic [3:0]  dom;
        logic [1:0]  ap, flt, sz;
        if (use_ovr) begin
            frame = ovr_frame; sz = ovr_size; dom = ovr_dom; ap = ovr_ap;
        end else begin
            frame = pt_frame(va); sz = pt_size(va); dom = pt_dom(va); ap = pt_ap(va);
        end
        exp_pa = frame | (va & ((32'd1 << off_bits(sz)) - 32'd1));
        flt    = ref_fault(dom, ap, wr, priv, dacr);

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_priv = priv;
        dom_access = dacr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 R4 miss indication (busy)", {31'd0, busy}, {31'd0, exp_miss});
        if (busy) begin
            chk("R3 walk_req on miss", {31'd0, walk_req}, 32'd1);
            chk("R3 walk_vaddr", walk_vaddr, va);
            chk("R3 no response while walking", {31'd0, rsp_valid}, 32'd0);
            for (int k = 0; k < wdelay; k++) begin
                if (poke && k == 0) begin
                    req_valid = 1'b1; req_vaddr = 32'h0AAA_0000;
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk("R3 busy held until fill", {30'd0, busy, walk_req}, 32'd3);
                if (poke) chk("R11 walk address unchanged by new request", walk_vaddr, va);
            end
            walk_ack    = 1'b1;
            fill_pframe = frame; fill_size = sz; fill_dom = dom; fill_ap = ap;
            @(negedge clk);
            walk_ack = 1'b0;
            chk("R4 replay cycle busy, no response", {30'd0, busy, rsp_valid}, 32'd2);
            @(negedge clk);
        end
        chk("R1 R4 response valid", {30'd0, rsp_valid, busy}, 32'd2);
        chk("R1/R2 physical address", rsp_paddr, exp_pa);
        chk("R5 R7 domain fault", {31'd0, rsp_dom_fault}, {31'd0, flt[1]});
        chk("R6 R7 permission fault", {31'd0, rsp_perm_fault}, {31'd0, flt[0]});
        @(negedge clk);
        chk("R1 R11 single response pulse", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
    endtask

    // {va, write, priv, dom_access, expect miss}
    localparam int NV = 26;
    localparam logic [66:0] VECS [NV] = '{
        {32'h0012_3456, 1'b0, 1'b1, 32'h5555_5555, 1'b1},
        {32'h001F_FFFC, 1'b1, 1'b0, 32'h5555_5555, 1'b0},
        {32'h0010_0000, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0},
        {32'h0020_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1},
        {32'h0020_0010, 1'b0, 1'b0, 32'hAAAA_AAAA, 1'b0},
        {32'h1234_5678, 1'b1, 1'b0, 32'h5555_5555, 1'b1},
        {32'h1234_FFF0, 1'b0, 1'b0, 32'h5555_5555, 1'b0},
        {32'h1235_0000, 1'b0, 1'b1, 32'h1B1B_1B1B, 1'b1},
        {32'h2000_4123, 1'b1, 1'b1, 32'h5555_5555, 1'b1},
        {32'h2000_7FFF, 1'b0, 1'b0, 32'h5555_5555, 1'b0},
        {32'h2000_8000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1},
        {32'h3000_0400, 1'b0, 1'b0, 32'h5555_5555, 1'b1},
        {32'h3000_07FC, 1'b1, 1'b0, 32'h5555_5555, 1'b0},
        {32'h3000_0800, 1'b1, 1'b1, 32'h1B1B_1B1B, 1'b1},
        {32'h0012_0000, 1'b1, 1'b0, 32'h5555_5555, 1'b0},
        {32'h1234_0004, 1'b1, 1'b1, 32'h0000_0000, 1'b0},
        {32'h2000_4000, 1'b0, 1'b0, 32'h1B1B_1B1B, 1'b0},
        {32'h3000_0500, 1'b0, 1'b1, 32'hAAAA_AAAA, 1'b0},
        {32'h4012_3456, 1'b0, 1'b1, 32'h5555_5555, 1'b1},
        {32'hF000_0C00, 1'b1, 1'b0, 32'h5555_5555, 1'b1},
        {32'h0100_0000, 1'b1, 1'b0, 32'h5555_5555, 1'b1},
        {32'h0100_0004, 1'b1, 1'b1, 32'h5555_5555, 1'b0},
        {32'h0200_0000, 1'b1, 1'b0, 32'h5555_5555, 1'b1},
        {32'h0200_0008, 1'b0, 1'b0, 32'h5555_5555, 1'b0},
        {32'h0300_0000, 1'b1, 1'b0, 32'h5555_5555, 1'b1},
        {32'h0012_3000, 1'b1, 1'b1, 32'h5555_5555, 1'b0}
    };

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        req_priv = 1'b0; dom_access = '0; inval_all = 1'b0; walk_ack = 1'b0;
        fill_pframe = '0; fill_size = '0; fill_dom = '0; fill_ap = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {29'd0, busy, rsp_valid, walk_req}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            access(VECS[v][66:35], VECS[v][34], VECS[v][33], VECS[v][32:1],
                   VECS[v][0], v % 3, 1'b0, 1'b0);
        end

        // R11: request during a walk is dropped.
        access(32'h3000_0C00, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 2, 1'b1, 1'b0);

        // R8: invalidate removes a cached page.
        pulse_inval();
        access(32'h0012_3456, 1'b0, 1'b1, 32'h5555_5555, 1'b1, 0, 1'b0, 1'b0);

        // R9: fill every entry, then one more evicts the oldest.
        pulse_inval();
        for (int i = 0; i < 64; i++)
            access(32'h3100_0000 + 32'(i) * 32'h400, 1'b0, 1'b1, 32'hFFFF_FFFF,
                   1'b1, 0, 1'b0, 1'b0);
        access(32'h3100_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0);
        access(32'h3100_0000 + 63 * 32'h400, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0);
        access(32'h3100_0000 + 64 * 32'h400, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 0, 1'b0, 1'b0);
        access(32'h3100_0400, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0);
        access(32'h3100_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 0, 1'b0, 1'b0);

        // R10: 1 KB entry at index 0 overlapped by a 64 KB entry at index 1.
        pulse_inval();
        access(32'h3001_0400, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 0, 1'b0, 1'b0);
        access(32'h3001_0800, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1, 1'b0, 1'b1);
        access(32'h3001_0400, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0);
        access(32'h3001_0000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule